// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt requests from eight devices and presents them to a simple sequential processor. Each request line is caught on its rising edge in a pending flip-flop. The pending bits pass through an enable mask and then down a fixed daisy chain, where line 0 is at the head and wins over every other line. The processor sees a single interrupt request output. It answers with an acknowledge, and in the same handshake it receives the 3-bit code of the line that won.

The controller raises its request only in the cycle that follows a fetch-boundary strobe. An instruction that is still executing is therefore never interrupted. Each acknowledge pushes the current enable mask onto an in-service stack. The new mask admits only lines with a strictly lower index than the one just granted, so only a more urgent device can preempt the running handler. A return-from-interrupt pulse pops the stack and restores the previous mask.

A global enable flag also gates recognition. Every acknowledge clears it. Software sets it again, either inside a handler to allow nesting or after a return.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `int_req` and `vec_valid` are 0, `vec_out` is 0, no line is pending, and the global enable is cleared, so pending requests do not raise `int_req` until `gie_set` is pulsed.
- R2: A 0-to-1 transition on `irq_lines[i]` sets the pending bit of line i. The bit stays set after the line returns low, until that line is granted.
- R3: `int_req` can only go from 0 to 1 on the clock edge that samples `fetch_start` high. A request pending without a strobe leaves `int_req` at 0. The strobe is acted on only if the global enable is set, some pending line is admitted by the mask, and the stack is not full.
- R4: When several admitted lines are pending at the moment of acknowledge, the line with the lowest index is granted. The choice is made at acknowledge time, so a more urgent line that arrives while `int_req` waits is the one served.
- R5: An acknowledge (`int_ack` high while `int_req` is high) makes `vec_out` equal the granted index and raises `vec_valid` for exactly one cycle, both on the following edge. On that same edge `int_req` drops and the pending bit of the granted line is cleared.
- R6: An acknowledge clears the global enable. No new `int_req` is raised until `gie_set` is pulsed, even for a more urgent line.
- R7: While line k is in service, pending lines with index k or greater do not cause `int_req`. A pending line with index below k does cause `int_req` (preemption).
- R8: A `ret_int` pulse restores the mask that was in force before the most recent grant, so lines that were held back become eligible again. A `ret_int` with nothing in service is ignored.
- R9: A line held high generates one request only. After it is granted, it is not pending again until it falls and rises.
- R10: Once raised, `int_req` stays high until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 8 | Device request lines, index 0 most urgent |
| fetch_start | input | 1 | One-cycle strobe at the start of an instruction fetch |
| gie_set | input | 1 | Software pulse that sets the global enable |
| int_ack | input | 1 | Processor acknowledge of `int_req` |
| ret_int | input | 1 | Return-from-interrupt pulse |
| int_req | output | 1 | Registered interrupt request to the processor |
| vec_out | output | 3 | Index of the most recently granted line |
| vec_valid | output | 1 | One-cycle pulse marking a new `vec_out` |

## Verification
Single-line pulses isolate the edge capture and the gating by the fetch strobe and the global enable. A level held high separates edge capture from level sampling. Simultaneous multi-line pulses (7, 4 and 1), and a more urgent line arriving while `int_req` waits, show whether the chain order is applied and whether the choice is made at acknowledge time. Nested sequences send more urgent, equal and less urgent requests during service, then unwind through returns, including one extra return with an empty stack, so that preemption, masking and mask restoration are each checked against the code pushed into the scoreboard.

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] lines,
  input  logic [N_LINES-1:0] clr,
  output logic [N_LINES-1:0] pend
);
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] rise;

  assign rise = lines & ~prev_q;
  assign pend = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lines;
      pend_q <= (pend_q & ~clr) | rise;
    end
  end
endmodule

// File: rtl/irqc_chain.sv
module irqc_chain #(
  parameter int N_LINES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [N_LINES-1:0] cand,
  output logic [N_LINES-1:0] grant,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);
  logic [N_LINES:0] pass;

  assign pass[0] = 1'b1;

  for (genvar g = 0; g < N_LINES; g++) begin : g_link
    assign grant[g]  = cand[g] & pass[g];
    assign pass[g+1] = pass[g] & ~cand[g];
  end

  assign any = ~pass[N_LINES];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqc_mask_stack.sv
module irqc_mask_stack #(
  parameter int N_LINES = 8,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic               pop,
  input  logic [N_LINES-1:0] new_mask,
  output logic [N_LINES-1:0] mask,
  output logic               full,
  output logic               empty
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SP_W = $clog2(DEPTH + 1);

  logic [N_LINES-1:0] stk [DEPTH];
  logic [N_LINES-1:0] mask_q;
  logic [SP_W-1:0]    sp_q;
  logic [SP_W-1:0]    sp_m1;

  assign sp_m1 = sp_q - SP_W'(1);
  assign mask  = mask_q;
  assign full  = (sp_q == SP_W'(DEPTH));
  assign empty = (sp_q == '0);

  always_ff @(posedge clk) begin
    if (push && !full) stk[sp_q[AW-1:0]] <= mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      sp_q   <= '0;
    end else if (push && !full) begin
      mask_q <= new_mask;
      sp_q   <= sp_q + SP_W'(1);
    end else if (pop && !empty) begin
      mask_q <= stk[sp_m1[AW-1:0]];
      sp_q   <= sp_m1;
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int N_LINES     = 8,
  parameter int STACK_DEPTH = 8
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic [N_LINES-1:0]                          irq_lines,
  input  logic                                        fetch_start,
  input  logic                                        gie_set,
  input  logic                                        int_ack,
  input  logic                                        ret_int,
  output logic                                        int_req,
  output logic [((N_LINES > 1) ? $clog2(N_LINES) : 1)-1:0] vec_out,
  output logic                                        vec_valid
);
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] mask;
  logic [N_LINES-1:0] cand;
  logic [N_LINES-1:0] sel;
  logic [N_LINES-1:0] clr;
  logic [N_LINES-1:0] below;
  logic [IDX_W-1:0]   win_idx;
  logic               any;
  logic               full;
  logic               empty;
  logic               take;
  logic               pop;
  logic               int_req_q;
  logic               gie_q;
  logic               vec_valid_q;
  logic [IDX_W-1:0]   vec_q;

  irqc_req_latch #(.N_LINES(N_LINES)) u_latch (
    .clk(clk), .rst(rst), .lines(irq_lines), .clr(clr), .pend(pend)
  );

  assign cand = pend & mask;

  irqc_chain #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_chain (
    .cand(cand), .grant(sel), .idx(win_idx), .any(any)
  );

  assign take  = int_req_q & int_ack & any;
  assign pop   = ret_int & ~take;
  assign clr   = take ? sel : '0;
  assign below = mask & (sel - N_LINES'(1));

  irqc_mask_stack #(.N_LINES(N_LINES), .DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(take), .pop(pop), .new_mask(below),
    .mask(mask), .full(full), .empty(empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_req_q   <= 1'b0;
      gie_q       <= 1'b0;
      vec_valid_q <= 1'b0;
      vec_q       <= '0;
    end else begin
      vec_valid_q <= take;
      if (take) begin
        vec_q     <= win_idx;
        int_req_q <= 1'b0;
        gie_q     <= 1'b0;
      end else begin
        if (gie_set) gie_q <= 1'b1;
        if (fetch_start && gie_q && any && !full) int_req_q <= 1'b1;
      end
    end
  end

  assign int_req   = int_req_q;
  assign vec_out   = vec_q;
  assign vec_valid = vec_valid_q;
endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
  parameter int N_LINES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               int_req,
  input logic               int_ack,
  input logic               fetch_start,
  input logic               vec_valid,
  input logic               gie_en,
  input logic [N_LINES-1:0] grant
);
  p_rise_at_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(int_req) |-> $past(fetch_start));

  p_one_winner_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_ack_handshake_r5: assert property (@(posedge clk) disable iff (rst)
    (int_req && int_ack) |=> (vec_valid && !int_req));

  p_valid_cause_r5: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(int_req && int_ack));

  p_enable_cleared_r6: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> !gie_en);

  p_rise_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(int_req) |-> $past(gie_en));

  p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (int_req && !int_ack) |=> int_req);
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .int_req(int_req), .int_ack(int_ack),
  .fetch_start(fetch_start), .vec_valid(vec_valid), .gie_en(gie_q),
  .grant(sel)
);

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_lines = '0;
  logic       fetch_start = 1'b0;
  logic       gie_set = 1'b0;
  logic       int_ack = 1'b0;
  logic       ret_int = 1'b0;
  logic       int_req;
  logic [2:0] vec_out;
  logic       vec_valid;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  nest_irq_ctrl i_nest_irq_ctrl (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .fetch_start(fetch_start),
    .gie_set(gie_set), .int_ack(int_ack), .ret_int(ret_int),
    .int_req(int_req), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_lines(logic [7:0] m);
    irq_lines = irq_lines | m;
    tick();
    irq_lines = irq_lines & ~m;
  endtask

  task automatic fetch();
    fetch_start = 1'b1;
    tick();
    fetch_start = 1'b0;
  endtask

  task automatic enable();
    gie_set = 1'b1;
    tick();
    gie_set = 1'b0;
  endtask

  task automatic ret();
    ret_int = 1'b1;
    tick();
    ret_int = 1'b0;
  endtask

  task automatic ack_expect(int exp);
    exp_q.push_back(exp);
    int_ack = 1'b1;
    tick();
    int_ack = 1'b0;
    check("R5 int_req drop", int_req, 0);
    tick();
    check("R5 single pulse", vec_valid, 0);
  endtask

  task automatic serve(int exp);
    enable();
    fetch();
    check("R3 req on fetch", int_req, 1);
    ack_expect(exp);
  endtask

  // Scoreboard monitor: compares each granted code with the expected queue.
  always @(negedge clk) begin
    if (!rst && vec_valid) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected vec_valid", 1, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        check("R4/R5 vector", int'(vec_out), e);
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 int_req", int_req, 0);
    check("R1 vec_valid", vec_valid, 0);
    check("R1 vec_out", int'(vec_out), 0);
    fetch();
    check("R1 no request pending", int_req, 0);

    // R2 one-cycle pulse is held; R1 enable cleared at reset
    pulse_lines(8'h20);
    repeat (3) tick();
    fetch();
    check("R1 enable off after reset", int_req, 0);
    enable();
    repeat (4) tick();
    check("R3 no strobe, no req", int_req, 0);
    fetch();
    check("R2/R3 held pulse raises req", int_req, 1);
    repeat (3) tick();
    check("R10 req held", int_req, 1);
    ack_expect(5);

    // R6 enable cleared by ack; R7 preemption by line 2
    pulse_lines(8'h04);
    fetch();
    check("R6 no req while enable off", int_req, 0);
    serve(2);

    // R7 lower (6,3) and equal (2) requests masked during line 2 service
    pulse_lines(8'h48);
    enable();
    fetch();
    check("R7 lower masked", int_req, 0);
    pulse_lines(8'h04);
    fetch();
    check("R7 equal masked", int_req, 0);

    // R8 return restores mask below 5: 2 then 3 eligible
    ret();
    fetch();
    check("R8 restore enables req", int_req, 1);
    ack_expect(2);
    ret();
    ret();
    serve(3);
    ret();
    serve(6);
    ret();

    // R8 extra return on empty stack is ignored
    ret();
    pulse_lines(8'h10);
    serve(4);
    pulse_lines(8'h80);
    enable();
    fetch();
    check("R8 mask intact after empty ret", int_req, 0);
    pulse_lines(8'h02);
    fetch();
    check("R7 higher preempts", int_req, 1);
    ack_expect(1);
    ret();
    ret();
    serve(7);
    ret();

    // R9 held level requests once
    irq_lines[0] = 1'b1;
    tick();
    serve(0);
    ret();
    repeat (3) tick();
    enable();
    fetch();
    check("R9 held level no re-request", int_req, 0);
    irq_lines[0] = 1'b0;
    tick();

    // R4 simultaneous pulses served in chain order
    pulse_lines(8'h92);
    serve(1);
    ret();
    serve(4);
    ret();
    serve(7);
    ret();

    // R4 winner picked at ack time
    pulse_lines(8'h20);
    enable();
    fetch();
    check("R3 req for line 5", int_req, 1);
    pulse_lines(8'h01);
    check("R10 still waiting", int_req, 1);
    ack_expect(0);
    ret();
    serve(5);
    ret();

    repeat (3) tick();
    check("R5 all expected vectors seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule